// File: doc/BRIEF.md
# FPR High-Half Transfer Unit

This unit holds a bank of floating-point registers and carries out the two coprocessor moves that exchange 32 bits between a 64-bit general-register value and the upper half of a floating-point register. A move-from-high returns a sign-extended 32-bit word to the integer side. A move-to-high takes the low word of the supplied integer value and stores it. Both moves depend on a register-mode input. In wide mode every register holds 64 bits. In narrow mode each register holds only a 32-bit low word, and the upper half of an even register is its odd neighbour.

The pipeline presents one instruction word per cycle with a valid strobe, the integer source value, the mode bit and an FPU-enable bit. The result value, the destination index, the write-enable and the unusable flag come from registers one cycle later. A separate port loads the low word of any register so that test code can set up contents. Arithmetic is not part of this unit.

Top module: `fpr_hihalf_xfer`

## Requirements
- R1: A synchronous active-high reset clears every register half to zero and drives all outputs to zero. A move-from issued after reset returns zero in either mode.
- R2: An instruction is acted on only when bits 31:26 are 010001, bits 10:0 are zero, and bits 25:21 are 00011 (move-from-high) or 00111 (move-to-high). Any other word leaves the outputs at zero and the registers unchanged.
- R3: When the FPU-enable bit is low, a recognised move raises cop_unusable in the next cycle, keeps gpr_we low and changes no register.
- R4: In wide mode a move-from-high sets gpr_we and returns the upper word of register FS (bits 15:11) sign-extended to 64 bits. It also presents RT (bits 20:16) on gpr_wsel.
- R5: In wide mode a move-to-high writes gpr_src[31:0] into the upper word of register FS and leaves its low word unchanged.
- R6: In narrow mode with an even FS, a move-from-high returns the low word of register FS+1, sign-extended.
- R7: In narrow mode with an even FS, a move-to-high writes gpr_src[31:0] into the low word of register FS+1.
- R8: In narrow mode with an odd FS, a move-from-high returns 0x000000000BADF00D.
- R9: In narrow mode with an odd FS, a move-to-high writes 0xDEADC0DE into the low word of register FS.
- R10: Outputs change one clock edge after the valid cycle. A move-from in the cycle right after a move-to sees the newly written value, and every valid cycle produces exactly one output update.
- R11: The preload port writes pre_data into the low word of register pre_idx. If a narrow move-to writes the same low word in the same cycle, the move's value is kept. A wide move-to to the same register in the same cycle updates the upper word alongside the preload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction word is present this cycle |
| op_word | input | 32 | Instruction word |
| gpr_src | input | 64 | Integer source value |
| wide_mode | input | 1 | 1: 64-bit registers, 0: 32-bit registers |
| fpu_on | input | 1 | FPU usable |
| pre_we | input | 1 | Preload strobe |
| pre_idx | input | 5 | Preload register index |
| pre_data | input | 32 | Preload low-word value |
| gpr_we | output | 1 | Integer register write-enable |
| gpr_wsel | output | 5 | Integer destination index (RT) |
| gpr_wdata | output | 64 | Value for the integer register |
| cop_unusable | output | 1 | Coprocessor-unusable flag |

## Verification
The preload port and a move-to can target the same register in the same clock cycle. The bench provokes this in both modes. In narrow mode the move and the preload both aim at the same low word. In wide mode the move writes the upper word while the preload writes the lower one. The result is judged by reading the register back through narrow and wide move-from instructions in the following cycles and comparing against a model in which the move wins any clash on the low word.

// File: rtl/fhx_pkg.sv
package fhx_pkg;
  localparam logic [5:0]  MAJOR_COP      = 6'b010001;
  localparam logic [4:0]  SUB_FROM_HI    = 5'b00011;
  localparam logic [4:0]  SUB_TO_HI      = 5'b00111;
  localparam logic [31:0] ODD_READ_MARK  = 32'h0BADF00D;
  localparam logic [31:0] ODD_WRITE_MARK = 32'hDEADC0DE;

  typedef enum logic [1:0] {
    MV_NONE    = 2'd0,
    MV_FROM_HI = 2'd1,
    MV_TO_HI   = 2'd2
  } mv_kind_e;
endpackage

// File: rtl/fhx_decode.sv
module fhx_decode
  import fhx_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [31:0]      word,
  output mv_kind_e         kind,
  output logic [4:0]       rt,
  output logic [IDX_W-1:0] fs
);
  logic       shape_ok;
  logic [4:0] sub;

  assign sub      = word[25:21];
  assign shape_ok = (word[31:26] == MAJOR_COP) && (word[10:0] == 11'd0);
  assign rt       = word[20:16];
  assign fs       = word[11 +: IDX_W];

  always_comb begin
    kind = MV_NONE;
    if (shape_ok) begin
      if (sub == SUB_FROM_HI)    kind = MV_FROM_HI;
      else if (sub == SUB_TO_HI) kind = MV_TO_HI;
    end
  end
endmodule

// File: rtl/fhx_route.sv
module fhx_route
  import fhx_pkg::*;
#(
  parameter int HALF  = 32,
  parameter int IDX_W = 5
) (
  input  logic             go_to,
  input  logic             wide_mode,
  input  logic [IDX_W-1:0] fs,
  input  logic [HALF-1:0]  src_lo,
  input  logic [HALF-1:0]  rd_lo,
  input  logic [HALF-1:0]  rd_hi,
  output logic [IDX_W-1:0] rd_idx,
  output logic [HALF-1:0]  rd_word,
  output logic             lo_we,
  output logic [IDX_W-1:0] lo_idx,
  output logic [HALF-1:0]  lo_data,
  output logic             hi_we,
  output logic [IDX_W-1:0] hi_idx,
  output logic [HALF-1:0]  hi_data
);
  logic             fs_odd;
  logic [IDX_W-1:0] fs_pair;

  assign fs_odd  = fs[0];
  // For an even index this is index+1; for an odd index it is the index.
  assign fs_pair = fs | IDX_W'(1);

  always_comb begin
    rd_idx  = wide_mode ? fs : fs_pair;
    if (wide_mode)   rd_word = rd_hi;
    else if (fs_odd) rd_word = HALF'(ODD_READ_MARK);
    else             rd_word = rd_lo;
  end

  always_comb begin
    hi_we   = go_to && wide_mode;
    hi_idx  = fs;
    hi_data = src_lo;
    lo_we   = go_to && !wide_mode;
    lo_idx  = fs_pair;
    lo_data = fs_odd ? HALF'(ODD_WRITE_MARK) : src_lo;
  end
endmodule

// File: rtl/fhx_regfile.sv
module fhx_regfile #(
  parameter int NREG  = 32,
  parameter int HALF  = 32,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mv_lo_we,
  input  logic [IDX_W-1:0] mv_lo_idx,
  input  logic [HALF-1:0]  mv_lo_data,
  input  logic             mv_hi_we,
  input  logic [IDX_W-1:0] mv_hi_idx,
  input  logic [HALF-1:0]  mv_hi_data,
  input  logic             pre_we,
  input  logic [IDX_W-1:0] pre_idx,
  input  logic [HALF-1:0]  pre_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [HALF-1:0]  rd_lo,
  output logic [HALF-1:0]  rd_hi
);
  logic [HALF-1:0] lo_view [NREG];
  logic [HALF-1:0] hi_view [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic [HALF-1:0] lo_r;
    logic [HALF-1:0] hi_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_r <= '0;
        hi_r <= '0;
      end else begin
        if (mv_lo_we && mv_lo_idx == IDX_W'(g))
          lo_r <= mv_lo_data;
        else if (pre_we && pre_idx == IDX_W'(g))
          lo_r <= pre_data;
        if (mv_hi_we && mv_hi_idx == IDX_W'(g))
          hi_r <= mv_hi_data;
      end
    end

    assign lo_view[g] = lo_r;
    assign hi_view[g] = hi_r;
  end

  assign rd_lo = lo_view[rd_idx];
  assign rd_hi = hi_view[rd_idx];
endmodule

// File: rtl/fpr_hihalf_xfer.sv
module fpr_hihalf_xfer
  import fhx_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  localparam int HALF  = XLEN / 2,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [31:0]      op_word,
  input  logic [XLEN-1:0]  gpr_src,
  input  logic             wide_mode,
  input  logic             fpu_on,
  input  logic             pre_we,
  input  logic [IDX_W-1:0] pre_idx,
  input  logic [HALF-1:0]  pre_data,
  output logic             gpr_we,
  output logic [4:0]       gpr_wsel,
  output logic [XLEN-1:0]  gpr_wdata,
  output logic             cop_unusable
);
  mv_kind_e         kind;
  logic [4:0]       rt;
  logic [IDX_W-1:0] fs;
  logic             go_from, go_to, blocked;

  logic [IDX_W-1:0] rd_idx;
  logic [HALF-1:0]  rd_lo, rd_hi, rd_word;
  logic             mv_lo_we, mv_hi_we;
  logic [IDX_W-1:0] mv_lo_idx, mv_hi_idx;
  logic [HALF-1:0]  mv_lo_data, mv_hi_data;
  logic             unused_src_hi;

  assign unused_src_hi = ^gpr_src[XLEN-1:HALF];

  fhx_decode #(.IDX_W(IDX_W)) u_dec (
    .word (op_word),
    .kind (kind),
    .rt   (rt),
    .fs   (fs)
  );

  assign go_from = op_valid && fpu_on && (kind == MV_FROM_HI);
  assign go_to   = op_valid && fpu_on && (kind == MV_TO_HI);
  assign blocked = op_valid && !fpu_on && (kind != MV_NONE);

  fhx_route #(.HALF(HALF), .IDX_W(IDX_W)) u_route (
    .go_to     (go_to),
    .wide_mode (wide_mode),
    .fs        (fs),
    .src_lo    (gpr_src[HALF-1:0]),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .rd_idx    (rd_idx),
    .rd_word   (rd_word),
    .lo_we     (mv_lo_we),
    .lo_idx    (mv_lo_idx),
    .lo_data   (mv_lo_data),
    .hi_we     (mv_hi_we),
    .hi_idx    (mv_hi_idx),
    .hi_data   (mv_hi_data)
  );

  fhx_regfile #(.NREG(NREG), .HALF(HALF), .IDX_W(IDX_W)) u_rf (
    .clk        (clk),
    .rst        (rst),
    .mv_lo_we   (mv_lo_we),
    .mv_lo_idx  (mv_lo_idx),
    .mv_lo_data (mv_lo_data),
    .mv_hi_we   (mv_hi_we),
    .mv_hi_idx  (mv_hi_idx),
    .mv_hi_data (mv_hi_data),
    .pre_we     (pre_we),
    .pre_idx    (pre_idx),
    .pre_data   (pre_data),
    .rd_idx     (rd_idx),
    .rd_lo      (rd_lo),
    .rd_hi      (rd_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gpr_we       <= 1'b0;
      gpr_wsel     <= '0;
      gpr_wdata    <= '0;
      cop_unusable <= 1'b0;
    end else begin
      gpr_we       <= go_from;
      gpr_wsel     <= go_from ? rt : 5'd0;
      gpr_wdata    <= go_from ? {{HALF{rd_word[HALF-1]}}, rd_word} : '0;
      cop_unusable <= blocked;
    end
  end
endmodule

// File: rtl/fhx_checker.sv
module fhx_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            op_valid,
  input logic            fpu_on,
  input logic            wide_mode,
  input logic            fs_lsb,
  input logic            lo_we,
  input logic            hi_we,
  input logic            gpr_we,
  input logic [XLEN-1:0] gpr_wdata,
  input logic            cop_unusable
);
  localparam int HALF = XLEN / 2;

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!gpr_we && !cop_unusable && gpr_wdata == '0));

  p_unusable_excl_r3: assert property (@(posedge clk) disable iff (rst)
    cop_unusable |-> !gpr_we);

  p_unusable_cause_r3: assert property (@(posedge clk) disable iff (rst)
    cop_unusable |-> $past(op_valid && !fpu_on));

  p_no_write_when_off_r3: assert property (@(posedge clk) disable iff (rst)
    !fpu_on |-> (!lo_we && !hi_we));

  p_sign_extend_r4: assert property (@(posedge clk) disable iff (rst)
    gpr_we |-> (gpr_wdata[XLEN-1:HALF] == {HALF{gpr_wdata[HALF-1]}}));

  p_odd_marker_r8: assert property (@(posedge clk) disable iff (rst)
    (gpr_we && $past(!wide_mode && fs_lsb)) |-> (gpr_wdata == XLEN'(32'h0BADF00D)));

  p_we_follows_valid_r10: assert property (@(posedge clk) disable iff (rst)
    gpr_we |-> $past(op_valid && fpu_on));

  p_mode_split_r5: assert property (@(posedge clk) disable iff (rst)
    !(lo_we && hi_we));
endmodule

bind fpr_hihalf_xfer fhx_checker #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .op_valid     (op_valid),
  .fpu_on       (fpu_on),
  .wide_mode    (wide_mode),
  .fs_lsb       (op_word[11]),
  .lo_we        (mv_lo_we),
  .hi_we        (mv_hi_we),
  .gpr_we       (gpr_we),
  .gpr_wdata    (gpr_wdata),
  .cop_unusable (cop_unusable)
);

// File: tb/fpr_hihalf_xfer_test.sv
module fpr_hihalf_xfer_test;
  typedef struct {
    bit          we;
    logic [63:0] data;
    logic [4:0]  sel;
    bit          unus;
    int          req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [31:0] op_word = '0;
  logic [63:0] gpr_src = '0;
  logic        wide_mode = 1'b0;
  logic        fpu_on = 1'b1;
  logic        pre_we = 1'b0;
  logic [4:0]  pre_idx = '0;
  logic [31:0] pre_data = '0;
  logic        gpr_we;
  logic [4:0]  gpr_wsel;
  logic [63:0] gpr_wdata;
  logic        cop_unusable;

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  item_t q[$];
  logic [31:0] mlo [32];
  logic [31:0] mhi [32];

  always #10 clk = ~clk;

  fpr_hihalf_xfer uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word),
    .gpr_src(gpr_src), .wide_mode(wide_mode), .fpu_on(fpu_on),
    .pre_we(pre_we), .pre_idx(pre_idx), .pre_data(pre_data),
    .gpr_we(gpr_we), .gpr_wsel(gpr_wsel), .gpr_wdata(gpr_wdata),
    .cop_unusable(cop_unusable)
  );

  function automatic logic [63:0] sx(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [31:0] mk(input logic [4:0] sub, input logic [4:0] rt, input logic [4:0] fs);
    return {6'b010001, sub, rt, fs, 11'd0};
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 32; i++) begin
      mlo[i] = '0;
      mhi[i] = '0;
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [63:0] src, input bit wide,
                       input bit fon, input bit pwe, input logic [4:0] pidx,
                       input logic [31:0] pdat, input int req);
    item_t it;
    bit rec, frm, tom;
    logic [4:0] fs;
    @(negedge clk);
    op_valid = 1'b1; op_word = w; gpr_src = src; wide_mode = wide; fpu_on = fon;
    pre_we = pwe; pre_idx = pidx; pre_data = pdat;
    fs  = w[15:11];
    rec = (w[31:26] == 6'b010001) && (w[10:0] == 11'd0) &&
          (w[25:21] == 5'b00011 || w[25:21] == 5'b00111);
    frm = rec && (w[25:21] == 5'b00011);
    tom = rec && (w[25:21] == 5'b00111);
    it.we = 1'b0; it.data = '0; it.sel = '0; it.unus = 1'b0; it.req = req;
    if (rec && !fon) it.unus = 1'b1;
    else if (frm) begin
      it.we  = 1'b1;
      it.sel = w[20:16];
      if (wide)       it.data = sx(mhi[fs]);
      else if (fs[0]) it.data = sx(32'h0BADF00D);
      else            it.data = sx(mlo[fs | 5'd1]);
    end
    if (pwe) mlo[pidx] = pdat;
    if (tom && fon) begin
      if (wide)       mhi[fs] = src[31:0];
      else if (fs[0]) mlo[fs] = 32'hDEADC0DE;
      else            mlo[fs | 5'd1] = src[31:0];
    end
    q.push_back(it);
    @(posedge clk);
  endtask

  task automatic preload(input logic [4:0] idx, input logic [31:0] d);
    @(negedge clk);
    op_valid = 1'b0; pre_we = 1'b1; pre_idx = idx; pre_data = d;
    mlo[idx] = d;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    op_valid = 1'b0; pre_we = 1'b0; op_word = '0;
    repeat (n) @(posedge clk);
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    rst = 1'b1; op_valid = 1'b0; pre_we = 1'b0;
    clear_model();
    repeat (n) @(posedge clk);
    @(negedge clk);
    checks++;  // R1: outputs held at zero while reset is applied
    if (gpr_we !== 1'b0 || gpr_wdata !== '0 || cop_unusable !== 1'b0 || gpr_wsel !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual we=%b data=%h unus=%b expected 0/0/0",
               gpr_we, gpr_wdata, cop_unusable);
    end
    rst = 1'b0;
  endtask

  // Monitor: compare one output update per valid cycle.
  initial begin
    forever begin
      @(posedge clk);
      if (op_valid && !rst) begin
        @(negedge clk);
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R10 output without expectation: actual we=%b expected none", gpr_we);
        end else begin
          item_t e;
          e = q.pop_front();
          if (gpr_we !== e.we || gpr_wdata !== e.data || gpr_wsel !== e.sel ||
              cop_unusable !== e.unus) begin
            errors++;
            $display("FAIL R%0d: actual we=%b sel=%0d data=%h unus=%b expected we=%b sel=%0d data=%h unus=%b",
                     e.req, gpr_we, gpr_wsel, gpr_wdata, cop_unusable,
                     e.we, e.sel, e.data, e.unus);
          end
        end
      end
    end
  end

  initial begin
    clear_model();
    do_reset(3);
    // R1: registers read back as zero in both modes
    issue(mk(5'b00011, 5'd4, 5'd5), '0, 1'b1, 1'b1, 0, 0, 0, 1);
    issue(mk(5'b00011, 5'd2, 5'd4), '0, 1'b0, 1'b1, 0, 0, 0, 1);
    // R11 / R6: preload odd registers, narrow even read returns FS+1, sign-extended
    preload(5'd3, 32'h80001234);
    preload(5'd1, 32'h00000042);
    issue(mk(5'b00011, 5'd7, 5'd2), '0, 1'b0, 1'b1, 0, 0, 0, 6);
    issue(mk(5'b00011, 5'd8, 5'd0), '0, 1'b0, 1'b1, 0, 0, 0, 11);
    // R5 then R4 / R10 back-to-back: wide write upper, read it the next cycle
    issue(mk(5'b00111, 5'd0, 5'd3), 64'h12345678_9ABCDEF0, 1'b1, 1'b1, 0, 0, 0, 5);
    issue(mk(5'b00011, 5'd9, 5'd3), '0, 1'b1, 1'b1, 0, 0, 0, 10);
    issue(mk(5'b00011, 5'd9, 5'd2), '0, 1'b0, 1'b1, 0, 0, 0, 5);  // R5: low word kept
    issue(mk(5'b00111, 5'd0, 5'd1), 64'h0, 1'b1, 1'b1, 0, 0, 0, 5);
    issue(mk(5'b00111, 5'd0, 5'd1), 64'hFFFF_0000_3333_4444, 1'b1, 1'b1, 0, 0, 0, 5);
    issue(mk(5'b00011, 5'd31, 5'd1), '0, 1'b1, 1'b1, 0, 0, 0, 4);  // R4 positive value
    // R7 then immediate read (R10)
    issue(mk(5'b00111, 5'd0, 5'd6), 64'hAAAA_BBBB_7777_0001, 1'b0, 1'b1, 0, 0, 0, 7);
    issue(mk(5'b00011, 5'd3, 5'd6), '0, 1'b0, 1'b1, 0, 0, 0, 7);
    // R8 / R9: odd index markers
    issue(mk(5'b00011, 5'd5, 5'd9), '0, 1'b0, 1'b1, 0, 0, 0, 8);
    issue(mk(5'b00111, 5'd0, 5'd9), 64'h1111_2222_3333_4444, 1'b0, 1'b1, 0, 0, 0, 9);
    issue(mk(5'b00011, 5'd6, 5'd8), '0, 1'b0, 1'b1, 0, 0, 0, 9);
    // R3: FPU disabled blocks both moves and changes nothing
    issue(mk(5'b00111, 5'd0, 5'd6), 64'h5555_5555, 1'b0, 1'b0, 0, 0, 0, 3);
    issue(mk(5'b00011, 5'd2, 5'd6), '0, 1'b0, 1'b0, 0, 0, 0, 3);
    issue(mk(5'b00111, 5'd0, 5'd3), 64'h6666_6666, 1'b1, 1'b0, 0, 0, 0, 3);
    issue(mk(5'b00011, 5'd2, 5'd6), '0, 1'b0, 1'b1, 0, 0, 0, 3);
    issue(mk(5'b00011, 5'd2, 5'd3), '0, 1'b1, 1'b1, 0, 0, 0, 3);
    // R2: malformed words are ignored
    issue({6'b010000, 5'b00111, 5'd0, 5'd6, 11'd0}, 64'h9999, 1'b0, 1'b1, 0, 0, 0, 2);
    issue({6'b010001, 5'b00101, 5'd0, 5'd6, 11'd0}, 64'h9999, 1'b0, 1'b1, 0, 0, 0, 2);
    issue({6'b010001, 5'b00111, 5'd0, 5'd6, 11'd1}, 64'h9999, 1'b0, 1'b1, 0, 0, 0, 2);
    issue({6'b010001, 5'b00011, 5'd4, 5'd6, 11'h400}, '0, 1'b0, 1'b1, 0, 0, 0, 2);
    issue(mk(5'b00011, 5'd2, 5'd6), '0, 1'b0, 1'b1, 0, 0, 0, 2);
    // R11: same-cycle preload and move-to on one register
    issue(mk(5'b00111, 5'd0, 5'd10), 64'h0000_0000_B0B0_B0B0, 1'b0, 1'b1, 1, 5'd11, 32'hA0A0A0A0, 11);
    issue(mk(5'b00011, 5'd1, 5'd10), '0, 1'b0, 1'b1, 0, 0, 0, 11);
    issue(mk(5'b00111, 5'd0, 5'd13), 64'h0000_0000_C1C1_C1C1, 1'b1, 1'b1, 1, 5'd13, 32'hD2D2D2D2, 11);
    issue(mk(5'b00011, 5'd1, 5'd12), '0, 1'b0, 1'b1, 0, 0, 0, 11);
    issue(mk(5'b00011, 5'd1, 5'd13), '0, 1'b1, 1'b1, 0, 0, 0, 11);
    idle(3);
    // R1: reset in mid-run clears the contents
    do_reset(2);
    issue(mk(5'b00011, 5'd4, 5'd3), '0, 1'b1, 1'b1, 0, 0, 0, 1);
    issue(mk(5'b00011, 5'd4, 5'd10), '0, 1'b0, 1'b1, 0, 0, 0, 1);
    idle(3);
    checks++;  // R10: every valid cycle was matched by one output update
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R10 pending items: actual=%0d expected=0", q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule